// File: doc/BRIEF.md
# Byte-to-Word DMA Packer with Request Threshold

This block sits between a byte-wide receive/transmit FIFO and a 16-bit DMA data register. In the receive direction it takes the two bytes held at the output of a small holding pipeline, joins them into one 16-bit word and offers that word to the DMA engine. In the transmit direction it takes one 16-bit word per DMA cycle and pushes its two bytes into the FIFO on two consecutive clocks. An input pin picks which half of the word travels first.

A programmable threshold is compared with the FIFO fill level when receiving, or with its free space when transmitting, to raise a DMA request. The request falls after the DMA cycle that leaves too little data or room for another word. When receiving, it also falls at once when a tagged byte shows up in the holding pipeline, because tagged bytes must be taken out by software and never through the DMA path. The threshold is compared with the FIFO count alone. The two pipeline bytes sit outside that count, so a request needs the threshold plus two bytes to have arrived.

Top module: `dma_byte_packer`

## Requirements
- R1: `dir_tx` = 0 selects receive, where an accepted DMA cycle pulses `pipe_pop` and never `fifo_push`. `dir_tx` = 1 selects transmit, where an accepted DMA cycle never pulses `pipe_pop`.
- R2: In receive, `dma_rdata` holds holding slot 0 (the older byte) in bits 15:8 and slot 1 in bits 7:0 when `hi_first` = 1. When `hi_first` = 0 the two halves are swapped.
- R3: In transmit, an accepted word is pushed as two bytes, on the first and second cycles after acceptance. The first byte is bits 15:8 when `hi_first` (sampled at acceptance) = 1, and bits 7:0 when it is 0.
- R4: In receive, the request rises one cycle after `fifo_level` >= `thresh` while both holding slots are valid and untagged.
- R5: In transmit, the request rises one cycle after DEPTH - `fifo_level` >= `thresh`, provided that free space is at least 2.
- R6: In receive, a DMA cycle accepted while `fifo_level` < 2 is the last one: `dma_req` is low from the next cycle.
- R7: In transmit, a DMA cycle accepted while free space < 4 is the last one: `dma_req` stays low after the two pushes until the arming condition holds again.
- R8: In receive, `dma_req` drops in the same cycle that either holding slot is tagged or invalid, and the burst ends. A new request needs R4 again.
- R9: `dma_ack` while `dma_req` is low is ignored: no pop and no push follow.
- R10: Synchronous active-high `rst` clears the request and any half-pushed word.
- R11: In transmit, `dma_req` is low during the two push cycles and returns in the cycle after them if the burst is not over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_tx | input | 1 | 0 = receive, 1 = transmit |
| hi_first | input | 1 | 1 = bits 15:8 travel first |
| thresh | input | LVL_W | Request threshold in bytes |
| fifo_level | input | LVL_W | Bytes currently in the FIFO |
| pipe_data0 | input | 8 | Holding slot 0 byte (older) |
| pipe_valid0 | input | 1 | Slot 0 holds a byte |
| pipe_tag0 | input | 1 | Slot 0 byte is tagged |
| pipe_data1 | input | 8 | Holding slot 1 byte |
| pipe_valid1 | input | 1 | Slot 1 holds a byte |
| pipe_tag1 | input | 1 | Slot 1 byte is tagged |
| pipe_pop | output | 1 | Both holding slots consumed this cycle |
| fifo_push | output | 1 | Write `fifo_wdata` into the FIFO |
| fifo_wdata | output | 8 | Byte pushed into the FIFO |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge, one word per accepted cycle |
| dma_wdata | input | 16 | Word written by DMA (transmit) |
| dma_rdata | output | 16 | Word read by DMA (receive) |

## Verification
A request flag stuck high or cleared late shows as `dma_req` one cycle past the last served word. A flag that fails to clear on a tag shows in the same cycle the tag appears. A push sequencer that loses its place shows as a missing, doubled or swapped byte on `fifo_wdata` within two cycles of the acknowledge. A wrong arming comparison shows one cycle after the level crosses the threshold, so each scenario compares the ports on the exact cycle after every edge that matters.

// File: rtl/dma_packer_pkg.sv
package dma_packer_pkg;

    typedef struct packed {
        logic       valid;
        logic       tag;
        logic [7:0] data;
    } hold_slot_t;

    typedef enum logic [1:0] {
        SPLIT_IDLE   = 2'd0,
        SPLIT_FIRST  = 2'd1,
        SPLIT_SECOND = 2'd2
    } split_state_t;

    typedef struct packed {
        logic [7:0] first;
        logic [7:0] second;
    } byte_pair_t;

    // Word assembled from an older and a newer byte.
    function automatic logic [15:0] join_bytes(input logic [7:0] older,
                                               input logic [7:0] newer,
                                               input logic       upper_first);
        return upper_first ? {older, newer} : {newer, older};
    endfunction

    // Transmission order of a word's two halves.
    function automatic byte_pair_t split_word(input logic [15:0] w,
                                              input logic        upper_first);
        byte_pair_t p;
        p.first  = upper_first ? w[15:8] : w[7:0];
        p.second = upper_first ? w[7:0]  : w[15:8];
        return p;
    endfunction

endpackage

// File: rtl/dmapk_rx_join.sv
module dmapk_rx_join
    import dma_packer_pkg::*;
(
    input  hold_slot_t  slot0,
    input  hold_slot_t  slot1,
    input  logic        hi_first,
    output logic [15:0] word,
    output logic        word_ok
);
    always_comb begin
        word    = join_bytes(slot0.data, slot1.data, hi_first);
        word_ok = slot0.valid && slot1.valid && !slot0.tag && !slot1.tag;
    end
endmodule

// File: rtl/dmapk_tx_split.sv
module dmapk_tx_split
    import dma_packer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic [15:0] word,
    input  logic        hi_first,
    output logic        push,
    output logic [7:0]  push_byte,
    output logic        busy
);
    split_state_t state_q;
    byte_pair_t   pair_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SPLIT_IDLE;
            pair_q  <= '0;
        end else begin
            unique case (state_q)
                SPLIT_IDLE: begin
                    if (accept) begin
                        pair_q  <= split_word(word, hi_first);
                        state_q <= SPLIT_FIRST;
                    end
                end
                SPLIT_FIRST:  state_q <= SPLIT_SECOND;
                SPLIT_SECOND: state_q <= SPLIT_IDLE;
                default:      state_q <= SPLIT_IDLE;
            endcase
        end
    end

    always_comb begin
        push      = (state_q == SPLIT_FIRST) || (state_q == SPLIT_SECOND);
        push_byte = (state_q == SPLIT_SECOND) ? pair_q.second : pair_q.first;
        busy      = (state_q != SPLIT_IDLE);
    end
endmodule

// File: rtl/dmapk_req_ctrl.sv
module dmapk_req_ctrl #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_tx,
    input  logic [LVL_W-1:0] thresh,
    input  logic [LVL_W-1:0] level,
    input  logic             word_ok,
    input  logic             tx_busy,
    input  logic             ack,
    output logic             req,
    output logic             xfer
);
    localparam logic [LVL_W-1:0] DEPTH_L   = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] ONE_WORD  = LVL_W'(2);
    localparam logic [LVL_W-1:0] TWO_WORDS = LVL_W'(4);

    logic             armed_q;
    logic [LVL_W-1:0] room;
    logic             arm_rx, arm_tx, last_rx, last_tx, is_last;

    always_comb begin
        room    = DEPTH_L - level;
        arm_rx  = word_ok && (level >= thresh);
        arm_tx  = !tx_busy && (room >= thresh) && (room >= ONE_WORD);
        last_rx = level < ONE_WORD;
        last_tx = room < TWO_WORDS;
        is_last = dir_tx ? last_tx : last_rx;
        req     = armed_q && (dir_tx ? !tx_busy : word_ok);
        xfer    = req && ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (!armed_q) begin
            armed_q <= dir_tx ? arm_tx : arm_rx;
        end else if (xfer && is_last) begin
            armed_q <= 1'b0;
        end else if (!dir_tx && !word_ok) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_byte_packer.sv
module dma_byte_packer
    import dma_packer_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_tx,
    input  logic             hi_first,
    input  logic [LVL_W-1:0] thresh,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [7:0]       pipe_data0,
    input  logic             pipe_valid0,
    input  logic             pipe_tag0,
    input  logic [7:0]       pipe_data1,
    input  logic             pipe_valid1,
    input  logic             pipe_tag1,
    output logic             pipe_pop,
    output logic             fifo_push,
    output logic [7:0]       fifo_wdata,
    output logic             dma_req,
    input  logic             dma_ack,
    input  logic [15:0]      dma_wdata,
    output logic [15:0]      dma_rdata
);
    hold_slot_t s0, s1;
    logic       word_ok, tx_busy, xfer;

    assign s0 = '{valid: pipe_valid0, tag: pipe_tag0, data: pipe_data0};
    assign s1 = '{valid: pipe_valid1, tag: pipe_tag1, data: pipe_data1};

    dmapk_rx_join u_join (
        .slot0    (s0),
        .slot1    (s1),
        .hi_first (hi_first),
        .word     (dma_rdata),
        .word_ok  (word_ok)
    );

    dmapk_req_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_req (
        .clk     (clk),
        .rst     (rst),
        .dir_tx  (dir_tx),
        .thresh  (thresh),
        .level   (fifo_level),
        .word_ok (word_ok),
        .tx_busy (tx_busy),
        .ack     (dma_ack),
        .req     (dma_req),
        .xfer    (xfer)
    );

    dmapk_tx_split u_split (
        .clk       (clk),
        .rst       (rst),
        .accept    (xfer && dir_tx),
        .word      (dma_wdata),
        .hi_first  (hi_first),
        .push      (fifo_push),
        .push_byte (fifo_wdata),
        .busy      (tx_busy)
    );

    assign pipe_pop = xfer && !dir_tx;
endmodule

// File: rtl/dma_byte_packer_chk.sv
module dma_byte_packer_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             dir_tx,
    input logic             hi_first,
    input logic [LVL_W-1:0] fifo_level,
    input logic [7:0]       pipe_data0,
    input logic             pipe_valid0,
    input logic             pipe_tag0,
    input logic             pipe_valid1,
    input logic             pipe_tag1,
    input logic             pipe_pop,
    input logic             fifo_push,
    input logic [7:0]       fifo_wdata,
    input logic             dma_req,
    input logic             dma_ack,
    input logic [15:0]      dma_wdata,
    input logic [15:0]      dma_rdata
);
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

    assert_push_pair_R3: assert property (@(posedge clk) disable iff (rst)
        (dma_req && dma_ack && dir_tx) |=> fifo_push ##1 fifo_push ##1 !fifo_push);

    assert_push_order_R3: assert property (@(posedge clk) disable iff (rst)
        $past(dma_req && dma_ack && dir_tx) |->
            fifo_wdata == ($past(hi_first) ? $past(dma_wdata[15:8]) : $past(dma_wdata[7:0])));

    assert_pop_clean_R8: assert property (@(posedge clk) disable iff (rst)
        pipe_pop |-> (pipe_valid0 && pipe_valid1 && !pipe_tag0 && !pipe_tag1));

    assert_tx_room_R5: assert property (@(posedge clk) disable iff (rst)
        (dma_req && dir_tx) |-> (DEPTH_L - fifo_level) >= LVL_W'(2));

    assert_rx_last_R6: assert property (@(posedge clk) disable iff (rst)
        (dma_req && dma_ack && !dir_tx && fifo_level < LVL_W'(2)) |=> !dma_req);

    assert_tx_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> !dma_req);

    assert_rx_order_R2: assert property (@(posedge clk) disable iff (rst)
        (!dir_tx && dma_req) |->
            (hi_first ? dma_rdata[15:8] : dma_rdata[7:0]) == pipe_data0);

    assert_no_pop_in_tx_R1: assert property (@(posedge clk) disable iff (rst)
        $past(dir_tx) && dir_tx |-> !pipe_pop);
endmodule

bind dma_byte_packer dma_byte_packer_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dir_tx     (dir_tx),
    .hi_first   (hi_first),
    .fifo_level (fifo_level),
    .pipe_data0 (pipe_data0),
    .pipe_valid0(pipe_valid0),
    .pipe_tag0  (pipe_tag0),
    .pipe_valid1(pipe_valid1),
    .pipe_tag1  (pipe_tag1),
    .pipe_pop   (pipe_pop),
    .fifo_push  (fifo_push),
    .fifo_wdata (fifo_wdata),
    .dma_req    (dma_req),
    .dma_ack    (dma_ack),
    .dma_wdata  (dma_wdata),
    .dma_rdata  (dma_rdata)
);

// File: tb/tb_dma_byte_packer.sv
module tb_dma_byte_packer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             dir_tx, hi_first;
    logic [LVL_W-1:0] thresh, fifo_level;
    logic [7:0]       pipe_data0, pipe_data1;
    logic             pipe_valid0, pipe_tag0, pipe_valid1, pipe_tag1;
    logic             pipe_pop, fifo_push, dma_req, dma_ack;
    logic [7:0]       fifo_wdata;
    logic [15:0]      dma_wdata, dma_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_byte_packer #(.DEPTH(DEPTH), .LVL_W(LVL_W)) dut (
        .clk(clk), .rst(rst), .dir_tx(dir_tx), .hi_first(hi_first),
        .thresh(thresh), .fifo_level(fifo_level),
        .pipe_data0(pipe_data0), .pipe_valid0(pipe_valid0), .pipe_tag0(pipe_tag0),
        .pipe_data1(pipe_data1), .pipe_valid1(pipe_valid1), .pipe_tag1(pipe_tag1),
        .pipe_pop(pipe_pop), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_wdata(dma_wdata),
        .dma_rdata(dma_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic do_reset(input logic dir);
        @(negedge clk);
        rst = 1'b1; dir_tx = dir; hi_first = 1'b1; dma_ack = 1'b0; dma_wdata = '0;
        thresh = LVL_W'(3); fifo_level = '0;
        pipe_data0 = 8'h11; pipe_data1 = 8'h22;
        pipe_valid0 = 1'b1; pipe_valid1 = 1'b1; pipe_tag0 = 1'b0; pipe_tag1 = 1'b0;
        if (dir) fifo_level = LVL_W'(DEPTH);
        repeat (2) @(negedge clk);
        chk_eq("R10 req in reset", dma_req, 0);
        chk_eq("R10 push in reset", fifo_push, 0);
        rst = 1'b0;
    endtask

    task automatic t_rx_threshold();
        do_reset(1'b0);
        fifo_level = LVL_W'(2);
        @(negedge clk);
        chk_eq("R4 below threshold", dma_req, 0);
        fifo_level = LVL_W'(3);
        @(negedge clk);
        chk_eq("R4 at threshold", dma_req, 1);
    endtask

    task automatic t_rx_order();
        hi_first = 1'b1; #1;
        chk_eq("R2 upper first", dma_rdata, 16'h1122);
        hi_first = 1'b0; #1;
        chk_eq("R2 lower first", dma_rdata, 16'h2211);
        hi_first = 1'b1;
    endtask

    task automatic t_rx_last();
        fifo_level = LVL_W'(5);
        dma_ack = 1'b1; #1;
        chk_eq("R1 rx pop", pipe_pop, 1);
        @(negedge clk);
        dma_ack = 1'b0;
        chk_eq("R1 rx no push", fifo_push, 0);
        chk_eq("R6 burst continues", dma_req, 1);
        fifo_level = LVL_W'(1);
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        chk_eq("R6 last word drops req", dma_req, 0);
    endtask

    task automatic t_rx_tag();
        do_reset(1'b0);
        fifo_level = LVL_W'(4);
        @(negedge clk);
        chk_eq("R4 armed", dma_req, 1);
        pipe_tag1 = 1'b1; #1;
        chk_eq("R8 tag drops req", dma_req, 0);
        dma_ack = 1'b1; #1;
        chk_eq("R9 ack without req no pop", pipe_pop, 0);
        @(negedge clk);
        dma_ack = 1'b0;
        pipe_tag1 = 1'b0;
        fifo_level = LVL_W'(2); #1;
        chk_eq("R8 burst ended", dma_req, 0);
        @(negedge clk);
        chk_eq("R8 no rearm below threshold", dma_req, 0);
    endtask

    task automatic t_ignored_ack();
        do_reset(1'b1);
        thresh = LVL_W'(1);
        dma_wdata = 16'h5A5A;
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        chk_eq("R9 no push on full fifo", fifo_push, 0);
        @(negedge clk);
        chk_eq("R9 still no push", fifo_push, 0);
    endtask

    task automatic t_tx_split();
        do_reset(1'b1);
        thresh = LVL_W'(8);
        fifo_level = LVL_W'(10);
        @(negedge clk);
        chk_eq("R5 room below threshold", dma_req, 0);
        fifo_level = LVL_W'(8);
        @(negedge clk);
        chk_eq("R5 room at threshold", dma_req, 1);
        hi_first = 1'b1; dma_wdata = 16'hA1B2; dma_ack = 1'b1; #1;
        chk_eq("R1 tx no pop", pipe_pop, 0);
        @(negedge clk);
        dma_ack = 1'b0; dma_wdata = 16'h0000;
        chk_eq("R3 first push", fifo_push, 1);
        chk_eq("R3 first byte upper", fifo_wdata, 8'hA1);
        chk_eq("R11 req low in push", dma_req, 0);
        @(negedge clk);
        chk_eq("R3 second push", fifo_push, 1);
        chk_eq("R3 second byte lower", fifo_wdata, 8'hB2);
        chk_eq("R11 req low in push 2", dma_req, 0);
        @(negedge clk);
        chk_eq("R3 pushes end", fifo_push, 0);
        chk_eq("R11 req returns", dma_req, 1);
        hi_first = 1'b0; dma_wdata = 16'hC3D4; dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0; hi_first = 1'b1;
        chk_eq("R3 lower first byte", fifo_wdata, 8'hD4);
        @(negedge clk);
        chk_eq("R3 lower second byte", fifo_wdata, 8'hC3);
    endtask

    task automatic t_tx_last();
        do_reset(1'b1);
        thresh = LVL_W'(2);
        fifo_level = LVL_W'(13);
        @(negedge clk);
        chk_eq("R5 armed with room 3", dma_req, 1);
        dma_wdata = 16'h7788; dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        chk_eq("R7 push after last", fifo_push, 1);
        fifo_level = LVL_W'(14);
        @(negedge clk);
        fifo_level = LVL_W'(15);
        chk_eq("R7 req low in push", dma_req, 0);
        @(negedge clk);
        chk_eq("R7 req stays low", dma_req, 0);
        @(negedge clk);
        chk_eq("R7 no rearm with room 1", dma_req, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        t_rx_threshold();
        t_rx_order();
        t_rx_last();
        t_rx_tag();
        t_ignored_ack();
        t_tx_split();
        t_tx_last();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule